// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block turns one high-level flash operation into the exact series of bus write cycles that an asynchronous parallel NOR flash expects before it will act. A client presents an opcode, a target address and a data word with a valid/ready handshake. The sequencer then plays out the unlock and command writes for that operation on a simple write bus (address, data, write strobe). It holds each write until the bus side acknowledges it.

Six operations are supported: returning the device to array read, entering identification mode, entering query mode, programming one word, erasing one sector and erasing the whole device. Command offsets are word offsets. They are placed relative to a fixed device base address and are doubled when the attached device is 8 bits wide. Pin timing, reading results back and polling for completion are left to neighbouring logic.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, reqReady is 1, busWrite is 0 and errPulse is 0.
- R2: The identification, program, sector-erase and chip-erase sequences start with the same two writes: 0x00AA to command offset 0x555, then 0x0055 to command offset 0x2AA.
- R3: Program (opcode 3) is exactly four writes. The unlock pair is followed by 0x00A0 to offset 0x555, and the last write puts reqData at reqAddr.
- R4: Sector erase (opcode 4) is exactly six writes. After the unlock pair come 0x0080 to 0x555, 0x00AA to 0x555 and 0x0055 to 0x2AA, and the sequence ends with 0x0030 written to reqAddr.
- R5: Chip erase (opcode 5) is six writes. The first five match sector erase, and the sixth is 0x0010 to command offset 0x555.
- R6: Identification entry (opcode 1) is exactly three writes: the unlock pair, then 0x0090 to offset 0x555.
- R7: Query entry (opcode 2) is a single write of 0x0098 to command offset 0x055, with no unlock pair.
- R8: Read-reset (opcode 0) is a single write of 0x00F0 to DEV_BASE.
- R9: A command offset appears on busAddr as DEV_BASE + offset when byteMode is 0, and as DEV_BASE + 2*offset when byteMode is 1. byteMode is captured when the request is accepted. User addresses are driven unscaled.
- R10: Each write keeps busWrite, busAddr and busData steady until a cycle with busAck high. The strobe drops or the next step appears only after such a cycle.
- R11: A request is accepted when reqValid and reqReady are both high. reqReady is low from the cycle after acceptance until the cycle after the final acknowledge. Requests presented in that window, including in the cycle of the final acknowledge, have no effect.
- R12: Opcodes 6 and 7 are invalid. Such a request raises errPulse for exactly the next cycle, issues no bus write and leaves reqReady high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Operation request present |
| reqReady | output | 1 | Sequencer idle and able to accept |
| reqOp | input | 3 | Operation code (0..5 valid) |
| reqAddr | input | AW | Target word/sector address |
| reqData | input | DW | Data word for program |
| byteMode | input | 1 | 1 = 8-bit device, 0 = 16-bit device |
| busWrite | output | 1 | Write cycle requested |
| busAddr | output | AW | Write cycle address |
| busData | output | DW | Write cycle data |
| busAck | input | 1 | Current write cycle completed |
| errPulse | output | 1 | One-cycle flag for a rejected opcode |

## Verification
Two events can land in one clock: the acknowledge of a sequence's final write and a fresh request from the client. The bench provokes this by raising reqValid in the same cycle as the last busAck. It judges the result by seeing that no bus write begins in the following cycle while reqReady has returned high, and that the held request is then taken one cycle later and starts its own first write. Every operation is swept in both device widths with acknowledge delays of zero to two cycles. Stray requests are injected mid-sequence, and each write is compared against addresses and data computed arithmetically from the offsets.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [2:0] {
    OP_RESET = 3'd0,
    OP_IDENT = 3'd1,
    OP_QUERY = 3'd2,
    OP_PROG  = 3'd3,
    OP_SECT  = 3'd4,
    OP_CHIP  = 3'd5
  } opcode_t;

  localparam int STEP_W = 3;

  typedef struct packed {
    logic              load;
    logic              active;
    logic [STEP_W-1:0] step;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    SRC_CMD,
    SRC_BASE,
    SRC_USER_WORD,
    SRC_USER_SECTOR
  } addrSrc_t;

  function automatic logic opIsKnown(input logic [2:0] op);
    return op <= 3'd5;
  endfunction

  function automatic logic [STEP_W-1:0] opLength(input logic [2:0] op);
    case (op)
      3'd1:        return STEP_W'(3);
      3'd3:        return STEP_W'(4);
      3'd4, 3'd5:  return STEP_W'(6);
      default:     return STEP_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqOp,
  input  logic       busAck,
  output logic       reqReady,
  output logic       errPulse,
  output seqStrobe_t strb
);

  logic              busyQ;
  logic [STEP_W-1:0] stepQ;
  logic [STEP_W-1:0] lastQ;
  logic              errQ;
  logic              accept;
  logic              opOk;

  assign accept = reqValid && !busyQ;
  assign opOk   = opIsKnown(reqOp);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      stepQ <= '0;
      lastQ <= '0;
      errQ  <= 1'b0;
    end else begin
      errQ <= accept && !opOk;
      if (accept && opOk) begin
        busyQ <= 1'b1;
        stepQ <= '0;
        lastQ <= opLength(reqOp) - STEP_W'(1);
      end else if (busyQ && busAck) begin
        if (stepQ == lastQ) busyQ <= 1'b0;
        else                stepQ <= stepQ + STEP_W'(1);
      end
    end
  end

  assign reqReady    = !busyQ;
  assign errPulse    = errQ;
  assign strb.load   = accept && opOk;
  assign strb.active = busyQ;
  assign strb.step   = stepQ;

  // R11: a sequence only starts from an accepted request
  a_r11_start_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(reqValid && reqReady));

  // R11: step index never runs past the sequence length
  a_r11_step_in_range: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> stepQ <= lastQ);

  // R12: invalid opcode yields error and no bus activity
  a_r12_bad_op_error: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqOp > 3'd5) |=> (errPulse && !busyQ));

endmodule

// File: rtl/nor_seq_dp.sv
module nor_seq_dp
  import nor_seq_pkg::*;
#(
  parameter int            AW       = 24,
  parameter int            DW       = 16,
  parameter logic [AW-1:0] DEV_BASE = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    strb,
  input  logic [2:0]    reqOp,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  input  logic          byteMode,
  input  logic          busAck,
  output logic          busWrite,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busData
);

  localparam int OFF_W = 12;
  localparam int CMD_W = 8;

  opcode_t       opQ;
  logic [AW-1:0] addrQ;
  logic [DW-1:0] dataQ;
  logic          byteQ;

  addrSrc_t          src;
  logic [OFF_W-1:0]  cmdOff;
  logic [CMD_W-1:0]  cmdByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ   <= OP_RESET;
      addrQ <= '0;
      dataQ <= '0;
      byteQ <= 1'b0;
    end else if (strb.load) begin
      opQ   <= opcode_t'(reqOp);
      addrQ <= reqAddr;
      dataQ <= reqData;
      byteQ <= byteMode;
    end
  end

  // step table: address source, command offset and command byte
  always_comb begin
    src     = SRC_CMD;
    cmdOff  = 12'h555;
    cmdByte = 8'hAA;
    case (opQ)
      OP_RESET: begin src = SRC_BASE; cmdOff = 12'h000; cmdByte = 8'hF0; end
      OP_QUERY: begin cmdOff = 12'h055; cmdByte = 8'h98; end
      default: begin
        case (strb.step)
          3'd0: begin cmdOff = 12'h555; cmdByte = 8'hAA; end
          3'd1: begin cmdOff = 12'h2AA; cmdByte = 8'h55; end
          3'd2: begin
            cmdOff = 12'h555;
            if (opQ == OP_IDENT)     cmdByte = 8'h90;
            else if (opQ == OP_PROG) cmdByte = 8'hA0;
            else                     cmdByte = 8'h80;
          end
          3'd3: begin
            if (opQ == OP_PROG) src = SRC_USER_WORD;
            cmdOff = 12'h555; cmdByte = 8'hAA;
          end
          3'd4: begin cmdOff = 12'h2AA; cmdByte = 8'h55; end
          default: begin
            if (opQ == OP_CHIP) begin cmdOff = 12'h555; cmdByte = 8'h10; end
            else begin src = SRC_USER_SECTOR; cmdByte = 8'h30; end
          end
        endcase
      end
    endcase
  end

  always_comb begin
    case (src)
      SRC_BASE:        busAddr = DEV_BASE;
      SRC_USER_WORD,
      SRC_USER_SECTOR: busAddr = addrQ;
      default:         busAddr = DEV_BASE + (AW'(cmdOff) << byteQ);
    endcase
    busData = (src == SRC_USER_WORD) ? dataQ : DW'(cmdByte);
  end

  assign busWrite = strb.active;

  // R10: pending write keeps its address and data until acknowledged
  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && !busAck) |=> (busWrite && $stable(busAddr) && $stable(busData)));

  // R10: the write strobe only drops after an acknowledge
  a_r10_drop_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busWrite) |-> $past(busAck));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int            AW       = 24,
  parameter int            DW       = 16,
  parameter logic [AW-1:0] DEV_BASE = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [2:0]    reqOp,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  input  logic          byteMode,
  output logic          busWrite,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busData,
  input  logic          busAck,
  output logic          errPulse
);

  seqStrobe_t strb;

  nor_seq_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .busAck   (busAck),
    .reqReady (reqReady),
    .errPulse (errPulse),
    .strb     (strb)
  );

  nor_seq_dp #(.AW(AW), .DW(DW), .DEV_BASE(DEV_BASE)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqOp    (reqOp),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .byteMode (byteMode),
    .busAck   (busAck),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busData  (busData)
  );

endmodule

// File: tb/nor_cmd_seq_tb_top.sv
module nor_cmd_seq_tb_top;

  localparam int          AW   = 24;
  localparam int          DW   = 16;
  localparam logic [23:0] BASE = 24'h400000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [2:0]    reqOp = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic          byteMode = 1'b0;
  logic          busWrite;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busData;
  logic          busAck = 1'b0;
  logic          errPulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nor_cmd_seq #(.AW(AW), .DW(DW), .DEV_BASE(BASE)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData), .byteMode(byteMode),
    .busWrite(busWrite), .busAddr(busAddr), .busData(busData),
    .busAck(busAck), .errPulse(errPulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expLen(input int op);
    case (op)
      1: return 3;
      3: return 4;
      4, 5: return 6;
      default: return 1;
    endcase
  endfunction

  // expected k-th write, computed from R2..R9
  task automatic expWrite(input int op, input int k, input bit bm,
                          input logic [23:0] ua, input logic [15:0] ud,
                          output logic [23:0] ea, output logic [15:0] ed);
    int off;
    bit user;
    user = 0; off = 0; ed = 0;
    if (op == 0) begin off = 0; ed = 16'hF0; end
    else if (op == 2) begin off = 'h55; ed = 16'h98; end
    else if (k == 0) begin off = 'h555; ed = 16'hAA; end
    else if (k == 1) begin off = 'h2AA; ed = 16'h55; end
    else if (k == 2) begin
      off = 'h555;
      ed = (op == 1) ? 16'h90 : (op == 3) ? 16'hA0 : 16'h80;
    end
    else if (k == 3 && op == 3) begin user = 1; ed = ud; end
    else if (k == 3) begin off = 'h555; ed = 16'hAA; end
    else if (k == 4) begin off = 'h2AA; ed = 16'h55; end
    else if (op == 5) begin off = 'h555; ed = 16'h10; end
    else begin user = 1; ed = 16'h30; end
    ea = user ? ua : BASE + 24'(off * (bm ? 2 : 1));
  endtask

  function automatic string reqOf(input int op);
    case (op)
      0: return "R8";
      1: return "R6";
      2: return "R7";
      3: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic runOp(input int op, input bit bm, input int dly,
                       input logic [23:0] ua, input logic [15:0] ud, input bit lastCollide);
    logic [23:0] ea;
    logic [15:0] ed;
    int n;
    n = expLen(op);
    @(negedge clk);
    reqOp = 3'(op); reqAddr = ua; reqData = ud; byteMode = bm; reqValid = 1'b1;
    check("R11 ready before accept", 32'(reqReady), 1);
    @(negedge clk);
    reqValid = 1'b0;
    byteMode = ~bm; // R9: captured at accept, later changes ignored
    for (int k = 0; k < n; k++) begin
      expWrite(op, k, bm, ua, ud, ea, ed);
      check("R11 ready low during sequence", 32'(reqReady), 0);
      check("R10 write strobe", 32'(busWrite), 1);
      check({reqOf(op), "/R2/R9 address"}, 32'(busAddr), 32'(ea));
      check({reqOf(op), "/R2 data"}, 32'(busData), 32'(ed));
      for (int w = 0; w < dly; w++) begin
        reqValid = (w == 0);   // R11 stray request while busy
        reqOp = 3'd2;
        @(negedge clk);
        reqValid = 1'b0;
        check("R10 held without ack addr", 32'(busAddr), 32'(ea));
        check("R10 held without ack data", 32'(busData), 32'(ed));
        check("R10 strobe held", 32'(busWrite), 1);
      end
      busAck = 1'b1;
      if (k == n - 1 && lastCollide) begin
        reqValid = 1'b1; reqOp = 3'd0;
      end
      @(negedge clk);
      busAck = 1'b0;
    end
    check({reqOf(op), " write count / R11 idle"}, 32'(busWrite), 0);
    check("R11 ready after last ack", 32'(reqReady), 1);
    if (lastCollide) begin
      // request held from final-ack cycle is now taken
      @(negedge clk);
      reqValid = 1'b0;
      check("R11 collided request starts", 32'(busWrite), 1);
      check("R11 collided request data", 32'(busData), 32'h00F0);
      check("R11 collided request addr", 32'(busAddr), 32'(BASE));
      busAck = 1'b1;
      @(negedge clk);
      busAck = 1'b0;
      check("R11 collided request done", 32'(busWrite), 0);
    end
    byteMode = bm;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 ready at reset", 32'(reqReady), 1);
    check("R1 no write at reset", 32'(busWrite), 0);
    check("R1 no error at reset", 32'(errPulse), 0);

    for (int op = 0; op < 6; op++)
      for (int bm = 0; bm < 2; bm++)
        for (int d = 0; d < 3; d++)
          runOp(op, bit'(bm), d, 24'h012340 + 24'(op * 16 + d), 16'hC3A0 + 16'(op * 3 + d), 1'b0);

    // R11: new request in the same cycle as the final acknowledge
    runOp(3, 1'b0, 0, 24'h0000F0, 16'h1234, 1'b1);
    runOp(4, 1'b1, 1, 24'h7F0000, 16'h0000, 1'b1);

    // R12: invalid opcodes
    for (int op = 6; op < 8; op++) begin
      @(negedge clk);
      reqOp = 3'(op); reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      check("R12 error pulse", 32'(errPulse), 1);
      check("R12 no bus write", 32'(busWrite), 0);
      check("R12 ready stays high", 32'(reqReady), 1);
      @(negedge clk);
      check("R12 single-cycle pulse", 32'(errPulse), 0);
      check("R12 still no bus write", 32'(busWrite), 0);
    end

    // R12: valid request right after an invalid one is served normally
    runOp(2, 1'b1, 0, 24'h0, 16'h0, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule